// File: doc/BRIEF.md
# Video Control Register and Address Remapper

This block sits between a CPU I/O bus, a CRT controller and the video RAM of a character/bitmap display board. It decodes a 16-byte I/O window whose base can be moved by a two-bit strap. The lower half of the window selects the CRT controller's two registers: an index register and a data register. The upper half selects an 8-bit control register. System reset clears the control register.

The control register selects one of four 16 KiB video pages, because the CRT controller drives only 14 memory-address lines. It can invert the horizontal and vertical sync pulses independently, picks one of four character fonts, and turns on a bitmap (hires) mode. The block builds the 16-bit video RAM address from the page field and the controller's memory address. In hires mode, address bits 13 and 12 are replaced by raster-row bits 1 and 0. This works around the controller's small row count.

The block has no data streams, so there is no valid/ready handshake and no back-pressure. Every pin is a plain level. Decode, sync and address outputs are combinational. A register write takes effect at the clock edge on which it is sampled.

Top module: `vidctl_remap`

## Requirements
- R1: While `rst_n` is low, the control register is 0. This gives page 0, no sync inversion, font 0 and hires off. A write made before reset is cleared by reset.
- R2: The window base is set by `base_sel`: 0 gives 0x880, 1 gives 0x890, 2 gives 0xF80 and 3 gives 0xF90. While `io_en` is high and `io_addr` is at base+0..base+7, `crtc_cs` is 1 and `crtc_rs` equals `io_addr[0]`. Otherwise `crtc_cs` is 0.
- R3: While `io_en` is high and `io_addr` is at base+8..base+15, `ctl_cs` is 1, and `crtc_cs` and `ctl_cs` are never both 1. A clock edge with `ctl_cs`, `io_wr` and `phi2` all high loads `wdata` into the control register. The new value is visible after that edge.
- R4: No register change occurs for a write with `phi2` low, a write to the controller half of the window, a write outside the window, or a cycle with `io_en` low.
- R5: The control register layout is: bits [1:0] page, bit 2 hsync invert, bit 3 vsync invert, bits [5:4] font (driven on `font_sel`), bit 6 hires (driven on `hires`). Bit 7 changes no output.
- R6: `hsync_out` = `crtc_hs` XOR bit 2, and `vsync_out` = `crtc_vs` XOR bit 3, in the same cycle.
- R7: With hires off, `vaddr` = {page, `ma[13:0]`}.
- R8: With hires on, `vaddr` = {page, `ra[1]`, `ra[0]`, `ma[11:0]`}. Higher `ra` bits are unused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low system reset |
| base_sel | input | 2 | Window base strap |
| io_en | input | 1 | I/O access in progress |
| io_addr | input | 12 | I/O address |
| io_wr | input | 1 | Write strobe |
| phi2 | input | 1 | Bus clock phase, high = CPU phase |
| wdata | input | 8 | Write data |
| crtc_cs | output | 1 | CRT controller select |
| crtc_rs | output | 1 | Controller register select (0 index, 1 data) |
| ctl_cs | output | 1 | Control register select |
| crtc_hs | input | 1 | Raw horizontal sync |
| crtc_vs | input | 1 | Raw vertical sync |
| hsync_out | output | 1 | Horizontal sync after polarity |
| vsync_out | output | 1 | Vertical sync after polarity |
| ma | input | 14 | Controller memory address |
| ra | input | 4 | Controller raster row |
| font_sel | output | 2 | Character font select |
| hires | output | 1 | Bitmap mode flag |
| vaddr | output | 16 | Video RAM address |

## Verification
Decode, sync polarity and address outputs follow their inputs in the same cycle. The bench therefore drives an access at a falling edge and samples these outputs one nanosecond later, before the next rising edge. A control-register write lands at the rising edge that follows the drive. Its effects on `font_sel`, `hires`, the sync outputs and `vaddr` are checked at the next falling edge, one edge after the write. Ignored writes are checked at that same point against an unchanged model value.

// File: rtl/vc_pkg.sv
`timescale 1ns/1ps
package vc_pkg;
  localparam int IO_AW  = 12;
  localparam int PAGE_W = 2;
  localparam int FONT_W = 2;

  typedef struct packed {
    logic              rsvd;
    logic              hires;
    logic [FONT_W-1:0] font;
    logic              vs_inv;
    logic              hs_inv;
    logic [PAGE_W-1:0] page;
  } ctl_t;

  localparam int CTL_W = $bits(ctl_t);

  function automatic logic [IO_AW-1:0] window_base(input logic [1:0] sel);
    logic [IO_AW-1:0] b;
    b = 12'h880;
    if (sel[0]) b[4] = 1'b1;          // +0x010
    if (sel[1]) b[11:8] = 4'hF;       // 0x8xx -> 0xFxx
    return b;
  endfunction
endpackage

// File: rtl/vc_decode.sv
`timescale 1ns/1ps
module vc_decode
  import vc_pkg::*;
#(
  parameter int AW = IO_AW
) (
  input  logic          io_en,
  input  logic [AW-1:0] io_addr,
  input  logic [1:0]    base_sel,
  output logic          crtc_cs,
  output logic          crtc_rs,
  output logic          ctl_cs
);
  localparam int OFS_W = 4;

  logic [AW-1:0] base;
  logic          in_win;

  always_comb begin
    base    = window_base(base_sel);
    in_win  = io_en && (io_addr[AW-1:OFS_W] == base[AW-1:OFS_W]);
    crtc_cs = in_win && !io_addr[OFS_W-1];
    ctl_cs  = in_win &&  io_addr[OFS_W-1];
    crtc_rs = crtc_cs && io_addr[0];
  end
endmodule

// File: rtl/vc_ctlreg.sv
`timescale 1ns/1ps
module vc_ctlreg
  import vc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [CTL_W-1:0] wdata,
  output ctl_t             q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (we) q <= ctl_t'(wdata);
  end
endmodule

// File: rtl/vc_syncpol.sv
`timescale 1ns/1ps
module vc_syncpol #(
  parameter int N = 2
) (
  input  logic [N-1:0] sync_in,
  input  logic [N-1:0] inv,
  output logic [N-1:0] sync_out
);
  for (genvar i = 0; i < N; i++) begin : g_pol
    assign sync_out[i] = sync_in[i] ^ inv[i];
  end
endmodule

// File: rtl/vc_remap.sv
`timescale 1ns/1ps
module vc_remap #(
  parameter int MA_W   = 14,
  parameter int RA_W   = 4,
  parameter int PAGE_W = 2,
  parameter int SWAP_N = 2
) (
  input  logic [MA_W-1:0]        ma,
  input  logic [RA_W-1:0]        ra,
  input  logic [PAGE_W-1:0]      page,
  input  logic                   hires,
  output logic [PAGE_W+MA_W-1:0] vaddr
);
  localparam int SWAP_LO = MA_W - SWAP_N;

  for (genvar i = 0; i < MA_W; i++) begin : g_bit
    if (i >= SWAP_LO) begin : g_swap
      assign vaddr[i] = hires ? ra[i-SWAP_LO] : ma[i];
    end else begin : g_keep
      assign vaddr[i] = ma[i];
    end
  end
  assign vaddr[PAGE_W+MA_W-1:MA_W] = page;
endmodule

// File: rtl/vidctl_remap.sv
`timescale 1ns/1ps
module vidctl_remap
  import vc_pkg::*;
#(
  parameter int MA_W = 14,
  parameter int RA_W = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [1:0]             base_sel,
  input  logic                   io_en,
  input  logic [IO_AW-1:0]       io_addr,
  input  logic                   io_wr,
  input  logic                   phi2,
  input  logic [CTL_W-1:0]       wdata,
  output logic                   crtc_cs,
  output logic                   crtc_rs,
  output logic                   ctl_cs,
  input  logic                   crtc_hs,
  input  logic                   crtc_vs,
  output logic                   hsync_out,
  output logic                   vsync_out,
  input  logic [MA_W-1:0]        ma,
  input  logic [RA_W-1:0]        ra,
  output logic [FONT_W-1:0]      font_sel,
  output logic                   hires,
  output logic [PAGE_W+MA_W-1:0] vaddr
);
  localparam int SWAP_N = 2;

  ctl_t       ctl;
  logic       ctl_we;
  logic [1:0] pol_out;

  vc_decode #(.AW(IO_AW)) u_dec (
    .io_en   (io_en),
    .io_addr (io_addr),
    .base_sel(base_sel),
    .crtc_cs (crtc_cs),
    .crtc_rs (crtc_rs),
    .ctl_cs  (ctl_cs)
  );

  assign ctl_we = ctl_cs && io_wr && phi2;

  vc_ctlreg u_reg (
    .clk  (clk),
    .rst_n(rst_n),
    .we   (ctl_we),
    .wdata(wdata),
    .q    (ctl)
  );

  vc_syncpol #(.N(2)) u_pol (
    .sync_in ({crtc_vs, crtc_hs}),
    .inv     ({ctl.vs_inv, ctl.hs_inv}),
    .sync_out(pol_out)
  );
  assign hsync_out = pol_out[0];
  assign vsync_out = pol_out[1];

  vc_remap #(.MA_W(MA_W), .RA_W(RA_W), .PAGE_W(PAGE_W), .SWAP_N(SWAP_N)) u_map (
    .ma   (ma),
    .ra   (ra),
    .page (ctl.page),
    .hires(ctl.hires),
    .vaddr(vaddr)
  );

  assign font_sel = ctl.font;
  assign hires    = ctl.hires;
endmodule

// File: rtl/vidctl_remap_chk.sv
`timescale 1ns/1ps
module vidctl_remap_chk #(
  parameter int MA_W = 14,
  parameter int RA_W = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic                io_wr,
  input logic                phi2,
  input logic [7:0]          wdata,
  input logic                crtc_cs,
  input logic                ctl_cs,
  input logic                crtc_hs,
  input logic                crtc_vs,
  input logic                hsync_out,
  input logic                vsync_out,
  input logic [MA_W-1:0]     ma,
  input logic [RA_W-1:0]     ra,
  input logic [1:0]          font_sel,
  input logic                hires,
  input logic [MA_W+1:0]     vaddr
);
  logic wr_hit;
  assign wr_hit = ctl_cs && io_wr && phi2;

  a_r1_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (font_sel == 2'b00 && !hires && hsync_out == crtc_hs && vsync_out == crtc_vs));

  a_r3_excl_select: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({crtc_cs, ctl_cs}));

  a_r3_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit |=> (font_sel == $past(wdata[5:4]) && hires == $past(wdata[6])));

  a_r4_no_stray_write: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_hit && !$rose(rst_n)) |=> ($stable(font_sel) && $stable(hires)));

  a_r7_linear_map: assert property (@(posedge clk) disable iff (!rst_n)
    !hires |-> vaddr[MA_W-1:0] == ma);

  a_r8_hires_map: assert property (@(posedge clk) disable iff (!rst_n)
    hires |-> (vaddr[MA_W-1:MA_W-2] == ra[1:0] && vaddr[MA_W-3:0] == ma[MA_W-3:0]));
endmodule

bind vidctl_remap vidctl_remap_chk #(.MA_W(MA_W), .RA_W(RA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .phi2(phi2), .wdata(wdata),
  .crtc_cs(crtc_cs), .ctl_cs(ctl_cs), .crtc_hs(crtc_hs), .crtc_vs(crtc_vs),
  .hsync_out(hsync_out), .vsync_out(vsync_out), .ma(ma), .ra(ra),
  .font_sel(font_sel), .hires(hires), .vaddr(vaddr)
);

// File: tb/vidctl_remap_bench.sv
`timescale 1ns/1ps
module vidctl_remap_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  base_sel = 2'd0;
  logic        io_en = 1'b0;
  logic [11:0] io_addr = '0;
  logic        io_wr = 1'b0;
  logic        phi2 = 1'b0;
  logic [7:0]  wdata = '0;
  logic        crtc_cs, crtc_rs, ctl_cs;
  logic        crtc_hs = 1'b0, crtc_vs = 1'b0;
  logic        hsync_out, vsync_out;
  logic [13:0] ma = 14'h3A5C;
  logic [3:0]  ra = 4'b0110;
  logic [1:0]  font_sel;
  logic        hires;
  logic [15:0] vaddr;

  int n_chk = 0;
  int n_fail = 0;
  logic [7:0] m_ctl = 8'h00;

  always #5 clk = ~clk;

  vidctl_remap u_vidctl_remap (.*);

  // vector: {base_sel[1:0], addr[11:0], data[7:0], phi2, wr}
  localparam logic [23:0] VEC [8] = '{
    {2'd0, 12'h888, 8'h01, 1'b1, 1'b1},
    {2'd0, 12'h88F, 8'h46, 1'b1, 1'b1},
    {2'd0, 12'h884, 8'hFF, 1'b1, 1'b1},
    {2'd1, 12'h898, 8'h3B, 1'b1, 1'b1},
    {2'd1, 12'h888, 8'h00, 1'b1, 1'b1},
    {2'd2, 12'hF8C, 8'h92, 1'b0, 1'b1},
    {2'd2, 12'hF8C, 8'hE5, 1'b1, 1'b1},
    {2'd3, 12'hF9A, 8'h08, 1'b1, 1'b1}
  };

  function automatic logic [11:0] exp_base(input logic [1:0] s);
    case (s)
      2'd0: return 12'h880;
      2'd1: return 12'h890;
      2'd2: return 12'hF80;
      default: return 12'hF90;
    endcase
  endfunction

  function automatic logic [15:0] exp_vaddr(input logic [7:0] c);
    if (c[6]) return {c[1:0], ra[1:0], ma[11:0]};
    return {c[1:0], ma};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic check_outputs(input string tag);
    chk({tag, " R5 font"}, 32'(font_sel), 32'(m_ctl[5:4]));
    chk({tag, " R5 hires"}, 32'(hires), 32'(m_ctl[6]));
    chk({tag, " R6 hsync"}, 32'(hsync_out), 32'(crtc_hs ^ m_ctl[2]));
    chk({tag, " R6 vsync"}, 32'(vsync_out), 32'(crtc_vs ^ m_ctl[3]));
    chk({tag, " R7/R8 vaddr"}, 32'(vaddr), 32'(exp_vaddr(m_ctl)));
  endtask

  task automatic access(input logic [1:0] bs, input logic [11:0] a, input logic [7:0] d,
                        input logic p, input logic w);
    logic hit_win, hit_ctl;
    @(negedge clk);
    base_sel = bs; io_addr = a; wdata = d; phi2 = p; io_wr = w; io_en = 1'b1;
    #1;
    hit_win = (a[11:4] == exp_base(bs)[11:4]);
    hit_ctl = hit_win && a[3];
    chk("R2 crtc_cs", 32'(crtc_cs), 32'(hit_win && !a[3]));
    chk("R2 crtc_rs", 32'(crtc_rs), 32'(hit_win && !a[3] && a[0]));
    chk("R3 ctl_cs", 32'(ctl_cs), 32'(hit_ctl));
    if (hit_ctl && p && w) m_ctl = d;
    @(negedge clk);
    io_en = 1'b0; io_wr = 1'b0; phi2 = 1'b0;
  endtask

  initial begin
    #(200000 * 10);
    n_fail++;
    $display("FAIL watchdog expired (all requirements) actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check_outputs("R1 in reset");
    rst_n = 1'b1;
    @(negedge clk);
    check_outputs("R1 after reset");

    for (int i = 0; i < 8; i++) begin
      access(VEC[i][23:22], VEC[i][21:10], VEC[i][9:2], VEC[i][1], VEC[i][0]);
      check_outputs($sformatf("vec%0d R3/R4", i));
    end

    // R6: sync pass-through with raw level high, inversion from last write (vs inv)
    crtc_hs = 1'b1; crtc_vs = 1'b1; #1;
    check_outputs("R6 raw high");
    crtc_hs = 1'b0; crtc_vs = 1'b0;

    // R2: io_en low gives no select
    @(negedge clk);
    base_sel = 2'd0; io_addr = 12'h881; io_en = 1'b0; #1;
    chk("R2 idle crtc_cs", 32'(crtc_cs), 32'd0);
    chk("R2 idle ctl_cs", 32'(ctl_cs), 32'd0);

    // R4: strobe with io_en low must not write
    @(negedge clk);
    io_addr = 12'h889; wdata = 8'h70; io_wr = 1'b1; phi2 = 1'b1; io_en = 1'b0;
    @(negedge clk);
    io_wr = 1'b0; phi2 = 1'b0;
    check_outputs("R4 io_en low");

    // R5: bit 7 changes no output; each page value
    for (int p = 0; p < 4; p++) begin
      access(2'd0, 12'h88B, 8'h80 | 8'(p) | 8'h40, 1'b1, 1'b1);
      check_outputs($sformatf("R5 page %0d", p));
      chk("R5 page field", 32'(vaddr[15:14]), 32'(p));
    end

    // R8: higher ra bits unused
    ra = 4'b1101; #1;
    check_outputs("R8 high ra");

    // R1: reset mid-run clears
    @(negedge clk);
    rst_n = 1'b0; m_ctl = 8'h00; #1;
    check_outputs("R1 mid reset");
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_outputs("R1 released");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule